// File: doc/BRIEF.md
# Carry-less Barrett CRC-8 Reducer

This block takes a 16-bit folded value V and returns its 8-bit CRC: the remainder of V·x^8 divided by the generator polynomial, which by default is x^8+x^2+x+1 (0x107). The bits of V are read most significant first. There is no initial value and no final inversion. The block performs no polynomial long division. It first moves the upper byte of V sixteen bit positions to the right, using a multiply by the constant x^16 mod P. It then estimates the quotient from the precomputed inverse floor(x^16 / P) and multiplies that quotient back by P. XORing the product away leaves the remainder.

Every multiply is an 8×8 carry-less product. The 9-bit constants P and the inverse are split into a shift by eight plus an 8-bit multiply by their low byte. All constants are derived from the polynomial parameter at elaboration time. A fold engine that XORs many partial products into one 16-bit value places this block at its end. Up to three optional pipeline registers, one after each step, set the latency. The design accepts a new input every cycle.

Top module: `crc8_barrett_reduce`

## Requirements
- R1: For every 16-bit V presented with valid, out_crc equals the remainder of V·x^8 modulo the generator polynomial (MSB-first bitwise division, no preset, no final XOR).
- R2: With the default polynomial 0x107, V = 0xFFFE yields 0x23.
- R3: With the default polynomial 0x107, V = 0x1137 yields 0xC7.
- R4: With the default polynomial, V = 0x0000 yields 0x00. Any V whose upper byte is zero yields the carry-less product of its low byte and 0x07, reduced by the polynomial (so V = 0x0001 yields 0x07).
- R5: out_valid equals in_valid delayed by LATENCY cycles, where LATENCY is the number of enabled stage registers (3 by default). The out_crc shown with out_valid belongs to the input accepted LATENCY cycles earlier.
- R6: While rst_n is low, and after release until the first accepted input has travelled through the pipeline, out_valid is 0.
- R7: Inputs accepted in consecutive cycles each give one result in consecutive cycles, with no bubble. Cycles with in_valid low give cycles with out_valid low.
- R8: The polynomial is a parameter, given as its low byte. With low byte 0x1D (polynomial 0x11D) and all stage registers off, the block is purely combinational: out_valid follows in_valid and out_crc is the remainder of V·x^8 modulo 0x11D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears valid state |
| in_valid | input | 1 | in_data holds a value to reduce |
| in_data | input | 16 | Folded value V |
| out_valid | output | 1 | out_crc holds a result |
| out_crc | output | 8 | Reduced CRC of the matching input |

## Verification
All 65536 values of V are streamed back to back. This exposes any wrong product term in the fold, quotient or back-multiply steps, and any stall. A run of random values with random gaps in valid separates true latency alignment from a design that only works on a full stream. Directed values check the two known results, zero, and inputs with an empty upper byte, where the fold contributes nothing and only the quotient path acts. A second instance with another polynomial and no registers shows that the constants follow the parameter and that the zero-latency path is correct.

// File: rtl/crc8_barrett_reduce.sv
module crc8_barrett_reduce #(
  parameter logic [7:0] POLY_LO  = 8'h07,
  parameter bit         REG_FOLD = 1'b1,
  parameter bit         REG_QUOT = 1'b1,
  parameter bit         REG_OUT  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        out_valid,
  output logic [7:0]  out_crc
);

  localparam int         LATENCY = int'(REG_FOLD) + int'(REG_QUOT) + int'(REG_OUT);
  localparam logic [8:0] POLY    = {1'b1, POLY_LO};

  function automatic logic [15:0] clmul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) p = p ^ (16'(a) << i);
    return p;
  endfunction

  function automatic logic [7:0] pow_mod(input int n);
    logic [8:0] d;
    d = 9'd1;
    for (int i = 0; i < n; i++) begin
      d = d << 1;
      if (d[8]) d = d ^ POLY;
    end
    return d[7:0];
  endfunction

  function automatic logic [7:0] inverse_lo();
    logic [15:0] q;
    logic [8:0]  d;
    q = '0;
    d = 9'd1;
    for (int i = 0; i < 16; i++) begin
      d = d << 1;
      q = q << 1;
      if (d[8]) begin
        q[0] = 1'b1;
        d = d ^ POLY;
      end
    end
    return q[7:0];
  endfunction

  localparam logic [7:0] FOLD_K = pow_mod(16);
  localparam logic [7:0] INV_LO = inverse_lo();

  // step 1: fold upper byte right by 16 positions
  logic [15:0] u_c;
  assign u_c = clmul8(in_data[15:8], FOLD_K) ^ {in_data[7:0], 8'h00};

  logic        v1;
  logic [15:0] u1;
  if (REG_FOLD) begin : g_reg_fold
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= in_valid;
    always_ff @(posedge clk)
      if (in_valid) u1 <= u_c;
  end else begin : g_pass_fold
    assign v1 = in_valid;
    assign u1 = u_c;
  end

  // step 2: quotient estimate, inverse = x^8 + INV_LO
  logic [15:0] qm;
  logic [7:0]  q_c;
  assign qm  = clmul8(u1[15:8], INV_LO);
  assign q_c = u1[15:8] ^ qm[15:8];

  logic       v2;
  logic [7:0] ulo2, q2;
  if (REG_QUOT) begin : g_reg_quot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) v2 <= 1'b0;
      else        v2 <= v1;
    always_ff @(posedge clk)
      if (v1) begin
        ulo2 <= u1[7:0];
        q2   <= q_c;
      end
  end else begin : g_pass_quot
    assign v2   = v1;
    assign ulo2 = u1[7:0];
    assign q2   = q_c;
  end

  // step 3: remove quotient times polynomial, low byte only
  logic [15:0] bm;
  logic [7:0]  crc_c;
  assign bm    = clmul8(q2, POLY_LO);
  assign crc_c = ulo2 ^ bm[7:0];

  if (REG_OUT) begin : g_reg_out
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= v2;
    always_ff @(posedge clk)
      if (v2) out_crc <= crc_c;
  end else begin : g_pass_out
    assign out_valid = v2;
    assign out_crc   = crc_c;
  end

  function automatic logic [7:0] long_mod(input logic [23:0] x);
    logic [23:0] r;
    r = x;
    for (int i = 23; i >= 8; i--)
      if (r[i]) r = r ^ (24'(POLY) << (i - 8));
    return r[7:0];
  endfunction

  assert_fold_residue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> long_mod({8'h00, u_c}) == long_mod({in_data, 8'h00}));

  assert_quot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> (u1[15:8] ^ q_c ^ clmul8(q_c, POLY_LO) >> 8) == 16'h0000);

  assert_valid_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));

  if (LATENCY > 0) begin : g_lat_chk
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) >= LATENCY) |-> out_valid == $past(in_valid, LATENCY));

    assert_crc_residue_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) >= LATENCY && out_valid) |->
        out_crc == long_mod({$past(in_data, LATENCY), 8'h00}));
  end

endmodule

// File: tb/sim_crc8_barrett_reduce.sv
module sim_crc8_barrett_reduce;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid, alt_valid;
  logic [7:0]  out_crc, alt_crc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        hv [LAT];
  logic [15:0] hd [LAT];

  always #2 clk = ~clk;

  crc8_barrett_reduce u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_crc(out_crc));

  crc8_barrett_reduce #(.POLY_LO(8'h1D), .REG_FOLD(1'b0), .REG_QUOT(1'b0), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(alt_valid), .out_crc(alt_crc));

  function automatic logic [7:0] ref_crc(input logic [8:0] poly, input logic [15:0] v);
    logic [23:0] r;
    r = {v, 8'h00};
    for (int i = 23; i >= 8; i--)
      if (r[i]) r = r ^ (24'(poly) << (i - 8));
    return r[7:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check pipeline output, shift history, drive new input
  task automatic step(input logic v, input logic [15:0] d, input string req);
    @(negedge clk);
    check("R5 valid", 16'(out_valid), 16'(hv[LAT-1]));
    if (hv[LAT-1]) check(req, 16'(out_crc), 16'(ref_crc(9'h107, hd[LAT-1])));
    for (int i = LAT - 1; i > 0; i--) begin
      hv[i] = hv[i-1];
      hd[i] = hd[i-1];
    end
    hv[0] = v;
    hd[0] = d;
    in_valid = v;
    in_data  = d;
    #1;
    check("R8 valid", 16'(alt_valid), 16'(v));
    if (v) check("R8 crc", 16'(alt_crc), 16'(ref_crc(9'h11D, d)));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LAT; i++) begin
      hv[i] = 1'b0;
      hd[i] = '0;
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R6 reset", 16'(out_valid), 16'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0, "R6");
    step(1'b0, 16'h0, "R6");

    step(1'b1, 16'hFFFE, "R2");
    step(1'b1, 16'h1137, "R3");
    step(1'b1, 16'h0000, "R4 zero");
    step(1'b1, 16'h0001, "R4 low byte");
    step(1'b0, 16'h0000, "R4");
    step(1'b1, 16'h00A5, "R4 low byte");
    step(1'b1, 16'h00FF, "R4 low byte");
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 16'h0, "R7");

    for (int i = 0; i < 65536; i++) step(1'b1, 16'(i), "R1 exhaustive R7");

    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, 16'($urandom), "R1 random R5");

    step(1'b1, 16'h1137, "R3");
    step(1'b1, 16'hFFFE, "R2");
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 16'h0, "R7 drain");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule